// File: doc/BRIEF.md
# Decrement-and-Branch Loop Unit

This block carries out a counting loop-closing instruction against a private bank of sixteen 32-bit general registers. A one-cycle start strobe names a count register and a second register, and picks one of two forms. In the register form the branch target comes from the second register. In the indexed form it comes from a storage address that logic outside the block has already computed. The count register is always decremented and written back. A branch is reported whenever the decremented count is not zero.

Results appear one cycle after the strobe. A single-cycle done pulse comes out together with the taken flag, a 24-bit target and the condition code, which passes through unchanged. In the register form, the target is read before the decrement is stored, so naming the same register in both fields is safe. A separate load port and an asynchronous read port give access to the register bank, so it can be set up and inspected.

Top module: `lcb_unit`

## Requirements
- R1: On a start strobe the count register named by `cnt_sel_i` is replaced by its value minus one, modulo 2^32. For example, 0 becomes 0xFFFFFFFF and 0x80000000 becomes 0x7FFFFFFF.
- R2: `taken_o` is 1 exactly when the decremented count is nonzero and the form permits a branch (R4). A starting count of 1 gives 0 and no branch.
- R3: In register form (`fmt_idx_i`=0), `target_o` is the low 24 bits [23:0] of the register named by `tgt_sel_i`.
- R4: In register form with `tgt_sel_i`=0, `taken_o` is 0 whatever the count, and the decrement of R1 still takes place.
- R5: When both selects name the same register in register form, `target_o` is built from the value before the decrement.
- R6: In indexed form (`fmt_idx_i`=1), `target_o` equals `mem_addr_i`, and a `tgt_sel_i` of 0 does not stop the branch.
- R7: `cc_o` takes the `cc_i` value presented with the strobe, unmodified. It holds that value while no strobe arrives.
- R8: `done_o` is high for exactly the one cycle after a strobe. `taken_o` and `target_o` change only in that cycle and otherwise hold.
- R9: With `ld_en_i` high and no strobe, `ld_data_i` is written to register `ld_sel_i` on the clock edge. `rd_data_o` always shows register `rd_sel_i` combinationally.
- R10: After reset all registers read 0 and `done_o`, `taken_o`, `target_o` and `cc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Execute strobe, one cycle |
| fmt_idx_i | input | 1 | 0 register form, 1 indexed form |
| cnt_sel_i | input | 4 | Count register number |
| tgt_sel_i | input | 4 | Target register number (register form) |
| mem_addr_i | input | 24 | Precomputed storage target (indexed form) |
| cc_i | input | 2 | Current condition code |
| ld_en_i | input | 1 | Register load enable |
| ld_sel_i | input | 4 | Register load number |
| ld_data_i | input | 32 | Register load data |
| rd_sel_i | input | 4 | Register read number |
| rd_data_o | output | 32 | Register read data |
| done_o | output | 1 | Completion pulse |
| taken_o | output | 1 | Branch taken |
| target_o | output | 24 | Branch target address |
| cc_o | output | 2 | Condition code, unchanged |

## Verification
The hardest case to reach is the alias case. In register form both selects name one register, so the target and the count are the same word. The write-back at the same edge must not leak into the reported target. The bench sweeps every pairing of count and target register in both forms, and this includes all sixteen aliased pairs. It loads the target register first and the count register last, so that in the aliased case the shared word holds the count value. The expected target is then worked out from the value before the decrement. Counts of 1, 0, 0x80000000 and an ordinary value drive the wrap and no-branch edges in every pairing.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  parameter int unsigned LCB_DW   = 32;
  parameter int unsigned LCB_NREG = 16;
  parameter int unsigned LCB_AW   = 24;
  parameter int unsigned LCB_CCW  = 2;

  typedef enum logic {
    FMT_REG = 1'b0,
    FMT_IDX = 1'b1
  } lcb_fmt_e;
endpackage

// File: rtl/lcb_regfile.sv
module lcb_regfile #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xw_en_i,
  input  logic [RW-1:0] xw_sel_i,
  input  logic [DW-1:0] xw_data_i,
  input  logic          lw_en_i,
  input  logic [RW-1:0] lw_sel_i,
  input  logic [DW-1:0] lw_data_i,
  input  logic [RW-1:0] ra_sel_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [RW-1:0] rb_sel_i,
  output logic [DW-1:0] rb_data_o,
  input  logic [RW-1:0] rt_sel_i,
  output logic [DW-1:0] rt_data_o
);
  logic [NREG-1:0][DW-1:0] mem_q;
  logic [NREG-1:0][DW-1:0] mem_d;
  logic [NREG-1:0]         mem_en;

  // Execution write-back has priority over the load port on the same entry.
  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic hit_x;
    logic hit_l;
    assign hit_x    = xw_en_i && (xw_sel_i == RW'(g));
    assign hit_l    = lw_en_i && (lw_sel_i == RW'(g));
    assign mem_en[g] = hit_x | hit_l;
    assign mem_d[g]  = hit_x ? xw_data_i : lw_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (mem_en[i]) mem_q[i] <= mem_d[i];
      end
    end
  end

  assign ra_data_o = mem_q[ra_sel_i];
  assign rb_data_o = mem_q[rb_sel_i];
  assign rt_data_o = mem_q[rt_sel_i];

  // R1: execution write-back lands in the named entry
  a_r1_exec_write: assert property (@(posedge clk) disable iff (!rst_n)
    xw_en_i |=> mem_q[$past(xw_sel_i)] == $past(xw_data_i));

  // R9: load lands when not overridden by execution
  a_r9_load_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_en_i && !(xw_en_i && xw_sel_i == lw_sel_i)) |=> mem_q[$past(lw_sel_i)] == $past(lw_data_i));
endmodule

// File: rtl/lcb_decr.sv
module lcb_decr #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] cnt_i,
  output logic [DW-1:0] cnt_o,
  output logic          zero_o
);
  // Wraps modulo 2^DW, no overflow reporting.
  always_comb begin
    cnt_o  = cnt_i - DW'(1);
    zero_o = (cnt_o == '0);
  end

  always_comb begin
    // R1: one and only one value maps to zero
    a_r1_zero_only_from_one: assert (zero_o == (cnt_i == DW'(1)));
  end
endmodule

// File: rtl/lcb_target.sv
module lcb_target
  import lcb_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 24,
  parameter int unsigned RW = 4
) (
  input  lcb_fmt_e      fmt_i,
  input  logic [RW-1:0] tgt_sel_i,
  input  logic [DW-1:0] tgt_val_i,
  input  logic [AW-1:0] mem_addr_i,
  output logic [AW-1:0] target_o,
  output logic          br_ok_o
);
  always_comb begin
    if (fmt_i == FMT_IDX) begin
      target_o = mem_addr_i;
      br_ok_o  = 1'b1;
    end else begin
      target_o = tgt_val_i[AW-1:0];
      br_ok_o  = (tgt_sel_i != '0);
    end
  end
endmodule

// File: rtl/lcb_unit.sv
module lcb_unit
  import lcb_pkg::*;
#(
  parameter int unsigned DW   = LCB_DW,
  parameter int unsigned NREG = LCB_NREG,
  parameter int unsigned AW   = LCB_AW,
  parameter int unsigned CCW  = LCB_CCW,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           fmt_idx_i,
  input  logic [RW-1:0]  cnt_sel_i,
  input  logic [RW-1:0]  tgt_sel_i,
  input  logic [AW-1:0]  mem_addr_i,
  input  logic [CCW-1:0] cc_i,
  input  logic           ld_en_i,
  input  logic [RW-1:0]  ld_sel_i,
  input  logic [DW-1:0]  ld_data_i,
  input  logic [RW-1:0]  rd_sel_i,
  output logic [DW-1:0]  rd_data_o,
  output logic           done_o,
  output logic           taken_o,
  output logic [AW-1:0]  target_o,
  output logic [CCW-1:0] cc_o
);
  logic [DW-1:0]  cnt_val;
  logic [DW-1:0]  tgt_val;
  logic [DW-1:0]  cnt_dec;
  logic           cnt_zero;
  logic [AW-1:0]  tgt_addr;
  logic           br_ok;
  lcb_fmt_e       fmt;

  logic           done_q,   done_d;
  logic           taken_q,  taken_d;
  logic [AW-1:0]  target_q, target_d;
  logic [CCW-1:0] cc_q,     cc_d;
  logic           res_en;

  assign fmt = fmt_idx_i ? FMT_IDX : FMT_REG;

  lcb_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .xw_en_i   (start_i),
    .xw_sel_i  (cnt_sel_i),
    .xw_data_i (cnt_dec),
    .lw_en_i   (ld_en_i),
    .lw_sel_i  (ld_sel_i),
    .lw_data_i (ld_data_i),
    .ra_sel_i  (cnt_sel_i),
    .ra_data_o (cnt_val),
    .rb_sel_i  (tgt_sel_i),
    .rb_data_o (tgt_val),
    .rt_sel_i  (rd_sel_i),
    .rt_data_o (rd_data_o)
  );

  lcb_decr #(.DW(DW)) i_decr (
    .cnt_i  (cnt_val),
    .cnt_o  (cnt_dec),
    .zero_o (cnt_zero)
  );

  // Target is taken from the pre-edge read, so it precedes the write-back.
  lcb_target #(.DW(DW), .AW(AW), .RW(RW)) i_tgt (
    .fmt_i      (fmt),
    .tgt_sel_i  (tgt_sel_i),
    .tgt_val_i  (tgt_val),
    .mem_addr_i (mem_addr_i),
    .target_o   (tgt_addr),
    .br_ok_o    (br_ok)
  );

  // Next-state logic
  always_comb begin
    res_en   = start_i;
    done_d   = start_i;
    taken_d  = br_ok && !cnt_zero;
    target_d = tgt_addr;
    cc_d     = cc_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      taken_q  <= 1'b0;
      target_q <= '0;
      cc_q     <= '0;
    end else begin
      done_q <= done_d;
      if (res_en) begin
        taken_q  <= taken_d;
        target_q <= target_d;
        cc_q     <= cc_d;
      end
    end
  end

  assign done_o   = done_q;
  assign taken_o  = taken_q;
  assign target_o = target_q;
  assign cc_o     = cc_q;

  // R2: branch decision follows the count and the form
  a_r2_taken_rule: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> taken_o == ($past(cnt_val) != DW'(1) && ($past(fmt_idx_i) || $past(tgt_sel_i) != '0)));

  // R4: zero target field in register form never branches
  a_r4_no_branch_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !fmt_idx_i && tgt_sel_i == '0) |=> !taken_o);

  // R5: aliased register gives the pre-decrement target
  a_r5_alias_target: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !fmt_idx_i && tgt_sel_i == cnt_sel_i) |=> target_o == $past(cnt_val[AW-1:0]));

  // R6: indexed form targets the storage address
  a_r6_idx_target: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && fmt_idx_i) |=> target_o == $past(mem_addr_i));

  // R7: condition code passes through untouched
  a_r7_cc_pass: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> cc_o == $past(cc_i));

  // R8: done only after a strobe, results hold otherwise
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(taken_o) && $stable(target_o) && $stable(cc_o)));
endmodule

// File: tb/test_lcb_unit.sv
`timescale 1ns/100ps
module test_lcb_unit;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        fmt_idx_i;
  logic [3:0]  cnt_sel_i;
  logic [3:0]  tgt_sel_i;
  logic [23:0] mem_addr_i;
  logic [1:0]  cc_i;
  logic        ld_en_i;
  logic [3:0]  ld_sel_i;
  logic [31:0] ld_data_i;
  logic [3:0]  rd_sel_i;
  logic [31:0] rd_data_o;
  logic        done_o;
  logic        taken_o;
  logic [23:0] target_o;
  logic [1:0]  cc_o;

  int n_checks;
  int n_errors;
  logic [31:0] bm [16];

  lcb_unit i_lcb_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_idx_i(fmt_idx_i),
    .cnt_sel_i(cnt_sel_i), .tgt_sel_i(tgt_sel_i), .mem_addr_i(mem_addr_i),
    .cc_i(cc_i), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .done_o(done_o),
    .taken_o(taken_o), .target_o(target_o), .cc_o(cc_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] sel, input logic [31:0] val);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_data_i = val;
    @(negedge clk);
    ld_en_i = 1'b0;
    bm[sel] = val;
  endtask

  task automatic read_chk(input string tag, input logic [3:0] sel, input logic [31:0] exp);
    rd_sel_i = sel;
    #0.5;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic run_op(input logic fi, input logic [3:0] r1, input logic [3:0] r2,
                        input logic [23:0] ma, input logic [1:0] cc);
    logic [31:0] cnt, res;
    logic [23:0] exp_t;
    logic        exp_k;
    string       ttag;
    cnt   = bm[r1];
    res   = cnt - 32'd1;
    exp_t = fi ? ma : bm[r2][23:0];
    exp_k = (res != 32'd0) && (fi || r2 != 4'd0);
    @(negedge clk);
    start_i = 1'b1; fmt_idx_i = fi; cnt_sel_i = r1; tgt_sel_i = r2;
    mem_addr_i = ma; cc_i = cc;
    @(negedge clk);
    start_i = 1'b0;
    bm[r1] = res;
    chk("R8 done", {31'd0, done_o}, 32'd1);
    if (!fi && r2 == 4'd0) chk("R4 no branch", {31'd0, taken_o}, {31'd0, exp_k});
    else                   chk("R2 taken", {31'd0, taken_o}, {31'd0, exp_k});
    if (fi)            ttag = "R6 idx target";
    else if (r1 == r2) ttag = "R5 alias target";
    else               ttag = "R3 reg target";
    chk(ttag, {8'd0, target_o}, {8'd0, exp_t});
    chk("R7 cc", {30'd0, cc_o}, {30'd0, cc});
    read_chk(r2 == 4'd0 && !fi ? "R4 decrement" : "R1 decrement", r1, res);
    cc_i = ~cc;
    @(negedge clk);
    chk("R8 done low", {31'd0, done_o}, 32'd0);
    chk("R8 hold target", {8'd0, target_o}, {8'd0, exp_t});
    chk("R7 cc hold", {30'd0, cc_o}, {30'd0, cc});
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] counts [4];
    n_checks = 0; n_errors = 0;
    counts[0] = 32'd1; counts[1] = 32'd0; counts[2] = 32'h8000_0000; counts[3] = 32'h0001_0003;
    rst_n = 1'b0; start_i = 1'b0; fmt_idx_i = 1'b0; cnt_sel_i = '0; tgt_sel_i = '0;
    mem_addr_i = '0; cc_i = '0; ld_en_i = 1'b0; ld_sel_i = '0; ld_data_i = '0; rd_sel_i = '0;
    for (int i = 0; i < 16; i++) bm[i] = 32'd0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 done", {31'd0, done_o}, 32'd0);
    chk("R10 taken", {31'd0, taken_o}, 32'd0);
    chk("R10 target", {8'd0, target_o}, 32'd0);
    chk("R10 cc", {30'd0, cc_o}, 32'd0);
    for (int i = 0; i < 16; i++) read_chk("R10 reg", 4'(i), 32'd0);

    // R9 load and read
    for (int i = 0; i < 16; i++) load(4'(i), 32'hC0DE_0000 + 32'(i) * 32'h0101);
    for (int i = 0; i < 16; i++) read_chk("R9 load read", 4'(i), 32'hC0DE_0000 + 32'(i) * 32'h0101);

    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int k = 0; k < 4; k++) begin
            load(4'(b), 32'h5A00_0000 ^ (32'(b) << 20) ^ (32'(k) * 32'h0003_0501) ^ 32'(a));
            load(4'(a), counts[k]);
            run_op(f[0], 4'(a), 4'(b), 24'hA0_0000 ^ 24'(a * 16 + b) ^ (24'(k) << 12),
                   2'(a + b + k));
          end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule